// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block RAM

This block models a 4,608-bit embedded memory that two independent ports share. Each port is fixed at elaboration to one of nine logical shapes, from 4,096 one-bit words up to 128 words of 36 bits. Both shapes address the same physical bits. One port can therefore write wide words that the other reads as narrow slices, or the reverse. The widths that are multiples of nine carry one parity bit with each eight data bits. The byte-multiple widths and the sub-byte widths use only the data bits.

Each port registers its address, write data, write strobe, read strobe and lane enables at a rising edge. The array is updated at the following edge, and the read result is loaded into the output register at that same edge. The model fixes several behaviours:

- A port that reads the address it is writing sees its own new data.
- A port that reads bits the other port is writing in the same cycle sees the previous contents.
- Port A prevails when both ports write the same bits in the same cycle.

Each port has its own synchronous clear. Both ports share one clock.

Top module: `mwram_dp`

## Requirements
- R1: The parameters `WA` and `WB` each take one of 1, 2, 4, 8, 9, 16, 18, 32 or 36. A port's depth is 4608/W for 9, 18 and 36, and 4096/W for the other widths. Its address width is log2 of that depth, and its highest address is readable.
- R2: Storage is 128 rows of 36 bits. A row holds four 9-bit lanes; lane k occupies bits 9k..9k+8, and bit 9k+8 is its parity bit. Port address a selects row a/S and slice a%S, where S is the number of slices per row. For widths 9, 18 and 36, slice s is row bits [s*W +: W]. For the other widths, slice s is data bits [s*W +: W] of the row's 32 data bits, which are counted lane by lane with parity skipped.
- R3: Inputs presented before rising edge k are registered at edge k. The output register shows the read result after edge k+1 and still holds its previous value after edge k.
- R4: When the registered read strobe is low, the output register keeps its value, even if the other port rewrites the bits it last read.
- R5: A port that writes and reads the same address in one access returns the newly written data in the enabled lanes and the previous data in the disabled lanes.
- R6: A port reading bits that the other port writes in the same access returns the previous contents. A later read returns the new contents.
- R7: When both ports write overlapping bits in the same access, port A's data is stored in the overlap, and port B's data is stored in the bits that only port B writes.
- R8: The lane enables mask writes per lane. There is one enable per 8 bits (byte-multiple widths) or per 9 bits (9-multiple widths), with enable bit i covering bits starting at i*8 or i*9. Widths below 8 have a single enable. A write with all enables low changes nothing.
- R9: Writes through a byte-multiple or sub-byte port never change parity bits.
- R10: After power-up, both output registers read zero until a read is performed.
- R11: A clear zeroes that port's output register at that edge and does not affect the other port. It also clears the port's input registers: address 0, write strobe 0, write data 0, read strobe 1 and all lane enables 1. As a result, the following edge loads the word at address 0. A write registered before the clearing edge still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| a_clr | input | 1 | Port A synchronous clear |
| a_addr | input | AWA (7 by default) | Port A word address |
| a_din | input | WA (36 by default) | Port A write data |
| a_we | input | 1 | Port A write strobe |
| a_re | input | 1 | Port A read strobe |
| a_be | input | NBEA (4 by default) | Port A lane enables |
| a_q | output | WA | Port A registered read data |
| b_clr | input | 1 | Port B synchronous clear |
| b_addr | input | AWB (9 by default) | Port B word address |
| b_din | input | WB (8 by default) | Port B write data |
| b_we | input | 1 | Port B write strobe |
| b_re | input | 1 | Port B read strobe |
| b_be | input | NBEB (1 by default) | Port B lane enables |
| b_q | output | WB | Port B registered read data |

## Verification
The memory is first filled with a distinct pattern per row through the wide port. Narrow reads at every slice position, including the top addresses, then show that the slice order and the skipping of parity bits are correct, rather than an address that happens to alias. Single-port accesses with mixed lane enables separate new data from old data lane by lane. Accesses that touch both ports in the same cycle separate three things: the write that wins, the old-data rule for the other port's read, and the bits that only the losing port wrote. Clears with and without a write in flight separate clearing the output register from arming a read of address 0.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  localparam int ROWS    = 128;
  localparam int ROW_W   = 36;
  localparam int ROW_AW  = 7;

  // widths 9/18/36 use every bit of a lane, the rest only its eight data bits
  function automatic bit has_par(input int w);
    return (w % 9) == 0;
  endfunction

  function automatic int slices_of(input int w);
    return has_par(w) ? ROW_W / w : 32 / w;
  endfunction

  function automatic int depth_of(input int w);
    return ROWS * slices_of(w);
  endfunction

  function automatic int aw_of(input int w);
    return $clog2(depth_of(w));
  endfunction

  function automatic int nbe_of(input int w);
    if (w < 8) return 1;
    return has_par(w) ? w / 9 : w / 8;
  endfunction

  function automatic int be_of(input int w, input int j);
    if (w < 8) return 0;
    return has_par(w) ? j / 9 : j / 8;
  endfunction

  // row bit reached by bit j of slice s
  function automatic int phys_pos(input int w, input int s, input int j);
    int d;
    if (has_par(w)) return s * w + j;
    d = s * w + j;
    return (d / 8) * 9 + (d % 8);
  endfunction

  function automatic logic [ROW_W-1:0] parity_mask();
    logic [ROW_W-1:0] m;
    m = '0;
    for (int k = 0; k < 4; k++) m[9*k+8] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/mwram_port.sv
module mwram_port
  import mwram_pkg::*;
#(
  parameter int W = 36,
  localparam int AW  = aw_of(W),
  localparam int NBE = nbe_of(W),
  localparam int NSL = slices_of(W)
)(
  input  logic              clk,
  input  logic              clr,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      din,
  input  logic              we,
  input  logic              re,
  input  logic [NBE-1:0]    be,
  output logic [ROW_AW-1:0] row,
  output logic [ROW_W-1:0]  wmask,
  output logic [ROW_W-1:0]  wdata,
  input  logic [ROW_W-1:0]  row_old,
  output logic [W-1:0]      q
);

  logic [AW-1:0]  addr_r = '0;
  logic [W-1:0]   din_r  = '0;
  logic           we_r   = 1'b0;
  logic           re_r   = 1'b0;
  logic [NBE-1:0] be_r   = '0;
  logic [W-1:0]   q_r    = '0;
  logic           live   = 1'b0;

  logic [W-1:0]     lane_w;
  logic [W-1:0]     rd;
  logic [ROW_W-1:0] merged;
  logic             rd_fire;
  int               sl;

  always_ff @(posedge clk) begin
    live <= 1'b1;
    if (clr) begin
      addr_r <= '0;
      din_r  <= '0;
      we_r   <= 1'b0;
      re_r   <= 1'b1;
      be_r   <= '1;
    end else begin
      addr_r <= addr;
      din_r  <= din;
      we_r   <= we;
      re_r   <= re;
      be_r   <= be;
    end
  end

  for (genvar j = 0; j < W; j++) begin : g_lane
    localparam int BI = be_of(W, j);
    assign lane_w[j] = be_r[BI];
  end

  always_comb begin
    sl  = int'(addr_r) % NSL;
    row = ROW_AW'(int'(addr_r) / NSL);
  end

  always_comb begin
    wmask = '0;
    wdata = '0;
    for (int j = 0; j < W; j++) begin
      wmask[6'(phys_pos(W, sl, j))] = we_r & lane_w[j];
      wdata[6'(phys_pos(W, sl, j))] = din_r[j];
    end
  end

  // own write is visible to own read in the same access
  assign merged = (row_old & ~wmask) | (wdata & wmask);

  always_comb begin
    rd = '0;
    for (int j = 0; j < W; j++) rd[j] = merged[6'(phys_pos(W, sl, j))];
  end

  assign rd_fire = re_r & ~clr;

  always_ff @(posedge clk) begin
    if (clr)       q_r <= '0;
    else if (re_r) q_r <= rd;
  end

  assign q = q_r;

  // R11
  clr_zeroes_q_chk: assert property (@(posedge clk) disable iff (!live)
    clr |=> (q == '0));

  // R11
  clr_arms_read_chk: assert property (@(posedge clk) disable iff (!live)
    clr |=> (re_r && (&be_r) && !we_r));

  // R4
  hold_q_chk: assert property (@(posedge clk) disable iff (!live)
    (!clr && !re_r) |=> $stable(q));

  // R5
  own_write_seen_chk: assert property (@(posedge clk) disable iff (!live)
    (rd_fire && we_r) |=> ((q & $past(lane_w)) == ($past(din_r) & $past(lane_w))));

endmodule

// File: rtl/mwram_array.sv
module mwram_array
  import mwram_pkg::*;
#(
  parameter bit PAR_A = 1'b1,
  parameter bit PAR_B = 1'b1
)(
  input  logic              clk,
  input  logic [ROW_AW-1:0] row_a,
  input  logic [ROW_W-1:0]  m_a,
  input  logic [ROW_W-1:0]  d_a,
  input  logic [ROW_AW-1:0] row_b,
  input  logic [ROW_W-1:0]  m_b,
  input  logic [ROW_W-1:0]  d_b,
  output logic [ROW_W-1:0]  old_a,
  output logic [ROW_W-1:0]  old_b
);

  localparam logic [ROW_W-1:0] PMASK = parity_mask();

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] base_a, new_a, new_b;
  logic             same_row, collide;
  logic             live = 1'b0;

  assign old_a    = mem[row_a];
  assign old_b    = mem[row_b];
  assign same_row = (row_a == row_b);
  assign collide  = same_row && |(m_a & m_b);

  // B's bits enter A's row image first, then A's bits overwrite them
  always_comb begin
    base_a = mem[row_a];
    if (same_row) base_a = (base_a & ~m_b) | (d_b & m_b);
    new_a = (base_a & ~m_a) | (d_a & m_a);
    new_b = (mem[row_b] & ~m_b) | (d_b & m_b);
  end

  always_ff @(posedge clk) begin
    live <= 1'b1;
    if (|m_b) mem[row_b] <= new_b;
    if (|m_a) mem[row_a] <= new_a;
  end

  // R7
  a_wins_overlap_chk: assert property (@(posedge clk) disable iff (!live)
    collide |=> ((mem[$past(row_a)] & $past(m_a)) == ($past(d_a) & $past(m_a))));

  // R7
  b_keeps_own_bits_chk: assert property (@(posedge clk) disable iff (!live)
    (same_row && |(m_b & ~m_a)) |=>
      ((mem[$past(row_b)] & $past(m_b & ~m_a)) == ($past(d_b) & $past(m_b & ~m_a))));

  // R9
  a_parity_untouched_chk: assert property (@(posedge clk) disable iff (!live)
    !PAR_A |-> ((m_a & PMASK) == '0));

  // R9
  b_parity_untouched_chk: assert property (@(posedge clk) disable iff (!live)
    !PAR_B |-> ((m_b & PMASK) == '0));

endmodule

// File: rtl/mwram_dp.sv
module mwram_dp
  import mwram_pkg::*;
#(
  parameter int WA = 36,
  parameter int WB = 8,
  localparam int AWA  = aw_of(WA),
  localparam int NBEA = nbe_of(WA),
  localparam int AWB  = aw_of(WB),
  localparam int NBEB = nbe_of(WB)
)(
  input  logic            clk,
  input  logic            a_clr,
  input  logic [AWA-1:0]  a_addr,
  input  logic [WA-1:0]   a_din,
  input  logic            a_we,
  input  logic            a_re,
  input  logic [NBEA-1:0] a_be,
  output logic [WA-1:0]   a_q,
  input  logic            b_clr,
  input  logic [AWB-1:0]  b_addr,
  input  logic [WB-1:0]   b_din,
  input  logic            b_we,
  input  logic            b_re,
  input  logic [NBEB-1:0] b_be,
  output logic [WB-1:0]   b_q
);

  logic [ROW_AW-1:0] row_a, row_b;
  logic [ROW_W-1:0]  m_a, d_a, m_b, d_b, old_a, old_b;

  mwram_port #(.W(WA)) u_port_a (
    .clk(clk), .clr(a_clr), .addr(a_addr), .din(a_din), .we(a_we), .re(a_re),
    .be(a_be), .row(row_a), .wmask(m_a), .wdata(d_a), .row_old(old_a), .q(a_q)
  );

  mwram_port #(.W(WB)) u_port_b (
    .clk(clk), .clr(b_clr), .addr(b_addr), .din(b_din), .we(b_we), .re(b_re),
    .be(b_be), .row(row_b), .wmask(m_b), .wdata(d_b), .row_old(old_b), .q(b_q)
  );

  mwram_array #(.PAR_A(has_par(WA)), .PAR_B(has_par(WB))) u_array (
    .clk(clk), .row_a(row_a), .m_a(m_a), .d_a(d_a),
    .row_b(row_b), .m_b(m_b), .d_b(d_b), .old_a(old_a), .old_b(old_b)
  );

endmodule

// File: tb/mwram_dp_tb_top.sv
module mwram_dp_tb_top;

  localparam int WA   = 36;
  localparam int WB   = 8;
  localparam int DA   = (WA % 9 == 0) ? 4608 / WA : 4096 / WA;
  localparam int DB   = (WB % 9 == 0) ? 4608 / WB : 4096 / WB;
  localparam int AWA  = $clog2(DA);
  localparam int AWB  = $clog2(DB);
  localparam int NBEA = (WA < 8) ? 1 : ((WA % 9 == 0) ? WA / 9 : WA / 8);
  localparam int NBEB = (WB < 8) ? 1 : ((WB % 9 == 0) ? WB / 9 : WB / 8);
  localparam logic [35:0] PM = 36'h804020100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            a_clr = 0, a_we = 0, a_re = 0;
  logic [AWA-1:0]  a_addr = '0;
  logic [WA-1:0]   a_din = '0;
  logic [NBEA-1:0] a_be = '0;
  logic [WA-1:0]   a_q;
  logic            b_clr = 0, b_we = 0, b_re = 0;
  logic [AWB-1:0]  b_addr = '0;
  logic [WB-1:0]   b_din = '0;
  logic [NBEB-1:0] b_be = '0;
  logic [WB-1:0]   b_q;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;
  logic [4607:0] ref_mem = '0;

  mwram_dp #(.WA(WA), .WB(WB)) dut_i (
    .clk(clk), .a_clr(a_clr), .a_addr(a_addr), .a_din(a_din), .a_we(a_we),
    .a_re(a_re), .a_be(a_be), .a_q(a_q), .b_clr(b_clr), .b_addr(b_addr),
    .b_din(b_din), .b_we(b_we), .b_re(b_re), .b_be(b_be), .b_q(b_q)
  );

  // flat model: global bit index of a port bit
  function automatic int pidx(input int w, input int a, input int j);
    int d;
    if (w % 9 == 0) return a * w + j;
    d = a * w + j;
    return (d / 8) * 9 + (d % 8);
  endfunction

  function automatic logic [4607:0] put(input logic [4607:0] m, input int w, input int a,
                                        input logic [35:0] d, input logic [3:0] be);
    for (int j = 0; j < w; j++)
      if (be[(w < 8) ? 0 : j / ((w % 9 == 0) ? 9 : 8)]) m[pidx(w, a, j)] = d[j];
    return m;
  endfunction

  function automatic logic [35:0] get(input logic [4607:0] m, input int w, input int a);
    logic [35:0] r = '0;
    for (int j = 0; j < w; j++) r[j] = m[pidx(w, a, j)];
    return r;
  endfunction

  function automatic logic [35:0] patt(input int r);
    return 36'h5A3C96E1F ^ (36'(r) * 36'h010204081);
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_we = 0; a_re = 0; b_we = 0; b_re = 0;
  endtask

  // one access on both ports; reads checked two negedges later
  task automatic op(input string tag,
                    input bit awe, input bit are, input int aad, input logic [35:0] adin, input logic [3:0] abe,
                    input bit bwe, input bit bre, input int bad, input logic [35:0] bdin, input logic [3:0] bbe);
    logic [35:0] ea, eb;
    @(negedge clk);
    a_we = awe; a_re = are; a_addr = AWA'(aad); a_din = adin[WA-1:0]; a_be = abe[NBEA-1:0];
    b_we = bwe; b_re = bre; b_addr = AWB'(bad); b_din = bdin[WB-1:0]; b_be = bbe[NBEB-1:0];
    ea = get(put(ref_mem, WA, aad, adin, awe ? abe : 4'b0), WA, aad);
    eb = get(put(ref_mem, WB, bad, bdin, bwe ? bbe : 4'b0), WB, bad);
    if (bwe) ref_mem = put(ref_mem, WB, bad, bdin, bbe);
    if (awe) ref_mem = put(ref_mem, WA, aad, adin, abe);
    @(negedge clk);
    idle();
    @(negedge clk);
    if (are) chk({tag, " port A"}, 36'(a_q), ea);
    if (bre) chk({tag, " port B"}, 36'(b_q), eb);
  endtask

  task automatic t_powerup(); // R10
    #5;
    chk("R10 port A zero after power-up", 36'(a_q), 36'h0);
    chk("R10 port B zero after power-up", 36'(b_q), 36'h0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < DA; r++) op("fill", 1, 0, r, patt(r), 4'hF, 0, 0, 0, 0, 0);
  endtask

  task automatic t_layout(); // R1 R2
    op("R2 narrow slice 0", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    op("R2 narrow slice 1", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    op("R2 narrow slice 2", 0, 0, 0, 0, 0, 0, 1, 2, 0, 0);
    op("R2 narrow slice 3", 0, 0, 0, 0, 0, 0, 1, 3, 0, 0);
    op("R1 narrow top-1", 0, 0, 0, 0, 0, 0, 1, DB - 2, 0, 0);
    op("R1 narrow top", 0, 1, DA - 1, 0, 0, 0, 1, DB - 1, 0, 0);
    op("R2 wide row 0", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 slice 1 is lane 1 data", 36'(a_q[16:9]), 36'(patt(0) >> 9) & 36'hFF);
  endtask

  task automatic t_latency(); // R3
    logic [35:0] prev, e;
    op("R3 prime", 0, 1, 9, 0, 0, 0, 0, 0, 0, 0);
    prev = get(ref_mem, WA, 9);
    e    = get(ref_mem, WA, 10);
    @(negedge clk); a_re = 1; a_addr = AWA'(10);
    @(negedge clk); idle();
    chk("R3 not changed after first edge", 36'(a_q), prev);
    @(negedge clk);
    chk("R3 changed after second edge", 36'(a_q), e);
  endtask

  task automatic t_hold(); // R4
    logic [35:0] old;
    op("R4 read", 0, 0, 0, 0, 0, 0, 1, 28, 0, 0);
    old = get(ref_mem, WB, 28);
    op("R4 rewrite", 1, 0, 7, ~patt(7), 4'hF, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R4 output held with read strobe low", 36'(b_q), old);
    op("R4 reread", 0, 0, 0, 0, 0, 0, 1, 28, 0, 0);
  endtask

  task automatic t_same_port(); // R5
    op("R5 full write+read", 1, 1, 20, 36'hABCDE1234, 4'hF, 0, 0, 0, 0, 0);
    chk("R5 new data", 36'(a_q), 36'hABCDE1234);
    op("R5 partial lanes", 1, 1, 21, 36'h0F0F0F0F0, 4'b0110, 0, 0, 0, 0, 0);
    op("R5 narrow write+read", 0, 0, 0, 0, 0, 1, 1, 84, 36'h5C, 4'h1);
    chk("R5 narrow new data", 36'(b_q), 36'h5C);
  endtask

  task automatic t_cross(); // R6
    logic [35:0] old;
    old = get(ref_mem, WB, 122);
    op("R6 B reads while A writes", 1, 0, 30, 36'h123456789, 4'hF, 0, 1, 122, 0, 0);
    chk("R6 old data on B", 36'(b_q), old);
    op("R6 B rereads", 0, 0, 0, 0, 0, 0, 1, 122, 0, 0);
    old = get(ref_mem, WA, 31);
    op("R6 A reads while B writes", 0, 1, 31, 0, 0, 1, 0, 125, 36'hE7, 4'h1);
    chk("R6 old data on A", 36'(a_q), old);
    op("R6 A rereads", 0, 1, 31, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_collide(); // R7
    op("R7 full overlap", 1, 0, 40, 36'h9876543A1, 4'hF, 1, 0, 161, 36'h3C, 4'h1);
    op("R7 readback", 0, 1, 40, 0, 0, 0, 1, 161, 0, 0);
    chk("R7 A data in overlap", 36'(b_q), (36'h9876543A1 >> 9) & 36'hFF);
    op("R7 disjoint lanes", 1, 0, 41, 36'h111111111, 4'b0001, 1, 0, 166, 36'hA5, 4'h1);
    op("R7 B-only lane kept", 0, 1, 41, 0, 0, 0, 1, 166, 0, 0);
    chk("R7 B data where only B wrote", 36'(b_q), 36'hA5);
  endtask

  task automatic t_byteen(); // R8
    logic [35:0] old;
    op("R8 alternate lanes", 1, 0, 50, ~patt(50), 4'b1010, 0, 0, 0, 0, 0);
    op("R8 readback", 0, 1, 50, 0, 0, 0, 0, 0, 0, 0);
    old = get(ref_mem, WB, 207);
    op("R8 enable low", 0, 0, 0, 0, 0, 1, 0, 207, 36'h00, 4'h0);
    op("R8 no change", 0, 0, 0, 0, 0, 0, 1, 207, 0, 0);
    chk("R8 masked write ignored", 36'(b_q), old);
  endtask

  task automatic t_parity(); // R9
    op("R9 set parity", 1, 0, 60, patt(60) | PM, 4'hF, 0, 0, 0, 0, 0);
    for (int s = 0; s < 4; s++) op("R9 narrow zero", 0, 0, 0, 0, 0, 1, 0, 240 + s, 36'h0, 4'h1);
    op("R9 wide read", 0, 1, 60, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 parity bits kept", 36'(a_q) & PM, PM);
  endtask

  task automatic t_clear(); // R11
    logic [35:0] qb_prev;
    op("R11 prime", 0, 1, 60, 0, 0, 0, 1, 3, 0, 0);
    qb_prev = 36'(b_q);
    @(negedge clk); a_clr = 1;
    @(negedge clk); a_clr = 0;
    chk("R11 output cleared", 36'(a_q), 36'h0);
    chk("R11 other port untouched", 36'(b_q), qb_prev);
    @(negedge clk);
    chk("R11 address 0 loaded after clear", 36'(a_q), get(ref_mem, WA, 0));
    @(negedge clk);
    a_we = 1; a_addr = AWA'(70); a_din = 36'hC0FFEE123; a_be = '1;
    ref_mem = put(ref_mem, WA, 70, 36'hC0FFEE123, 4'hF);
    @(negedge clk); idle(); a_clr = 1;
    @(negedge clk); a_clr = 0;
    chk("R11 cleared with write in flight", 36'(a_q), 36'h0);
    @(negedge clk);
    chk("R11 address 0 after second clear", 36'(a_q), get(ref_mem, WA, 0));
    op("R11 write in flight completed", 0, 1, 70, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_powerup();
    t_fill();
    t_layout();
    t_latency();
    t_hold();
    t_same_port();
    t_cross();
    t_collide();
    t_byteen();
    t_parity();
    t_clear();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

endmodule